// File: doc/BRIEF.md
# Priority Interrupt Chain with Vectored Acknowledge

This block gathers interrupt events from a row of sources into a single request line towards a processor. Each source has its own stage. A stage catches a rising edge on its input and holds it as a pending request. All pending requests are ORed onto one shared request output.

When the processor answers with a one-cycle acknowledge pulse, the pulse enters stage 0 and moves down the row. The first stage that holds a pending request takes the pulse. In the same cycle it drives its own vector byte and a valid strobe, and it drops its pending request at the next clock edge. A stage with nothing pending hands the pulse on unchanged. Lower stage indices therefore always win.

If the pulse passes the last stage without being taken, a spurious indication is raised for that cycle and the vector lines stay at zero.

Top module: `irq_daisy_chain`

## Requirements
- R1: A rising edge on `src_i[i]` (low in the previous clock, high in this clock) marks stage i pending at that clock edge. A source held high after its request has been serviced does not raise a new request.
- R2: `int_req_o` is high in the cycle after a stage becomes pending, and stays high while any stage is pending.
- R3: In a cycle with `int_ack_i` high and at least one stage pending, `vec_valid_o` is high in that same cycle and `vec_o` carries the vector of the lowest-index pending stage.
- R4: The vector of stage i is `(VEC_BASE + i*VEC_STRIDE)` truncated to VEC_W bits. With the defaults, the vector of stage i is 8'h20 + 4*i.
- R5: The granted stage's pending request is cleared at the clock edge that ends the acknowledge cycle. Every other pending request is kept.
- R6: `vec_o` is all zeros in every cycle in which `vec_valid_o` is low.
- R7: An acknowledge with no stage pending drives `spurious_o` high in that cycle, keeps `vec_valid_o` low and keeps `vec_o` at zero.
- R8: A rising edge on a stage's source in the same cycle that the stage is granted leaves that stage pending after the edge, so it is served again.
- R9: Reset clears every pending request, so `int_req_o`, `vec_valid_o` and `spurious_o` are low after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_i | input | N_STAGES | Per-stage interrupt source, edge sensitive |
| int_ack_i | input | 1 | One-cycle acknowledge pulse from the processor |
| int_req_o | output | 1 | Shared request, high while any stage is pending |
| vec_o | output | VEC_W | Vector of the granted stage, zero otherwise |
| vec_valid_o | output | 1 | High in an acknowledge cycle that found a pending stage |
| spurious_o | output | 1 | High in an acknowledge cycle that found nothing pending |

## Verification
The hardest case to reach from the ports is a new edge arriving on the very stage that is being granted. In that cycle the clear and the set act on the same bit. The stimulus first makes one stage pending with its source low. It then raises that source and the acknowledge in the same cycle, and expects the same vector to be served twice. Priority ordering is covered by setting several stages at once and then issuing acknowledges until one comes back spurious. The no-re-latch rule is covered by keeping a source high across its own service.

// File: rtl/irq_chain_pkg.sv
package irq_chain_pkg;

  // Vector word assigned to a stage: base plus index times stride.
  function automatic logic [31:0] stage_vector(input logic [31:0] base,
                                               input logic [31:0] stride,
                                               input int unsigned idx);
    return base + stride * idx;
  endfunction

endpackage

// File: rtl/irq_edge_latch.sv
module irq_edge_latch #(
  parameter int N_STAGES = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [N_STAGES-1:0] src_i,
  input  logic [N_STAGES-1:0] clr_i,
  output logic [N_STAGES-1:0] pend_o,
  output logic [N_STAGES-1:0] rise_o
);
  logic [N_STAGES-1:0] src_q;
  logic [N_STAGES-1:0] pend_q;

  assign rise_o = src_i & ~src_q;
  assign pend_o = pend_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_q  <= '0;
      pend_q <= '0;
    end else begin
      src_q  <= src_i;
      // A fresh edge wins over the clear of the same stage.
      pend_q <= rise_o | (pend_q & ~clr_i);
    end
  end
endmodule

// File: rtl/irq_ack_chain.sv
module irq_ack_chain #(
  parameter int          N_STAGES   = 8,
  parameter int          VEC_W      = 8,
  parameter logic [31:0] VEC_BASE   = 32'h20,
  parameter logic [31:0] VEC_STRIDE = 32'h4
) (
  input  logic                pend_i [N_STAGES],
  input  logic                ack_i,
  output logic [N_STAGES-1:0] grant_o,
  output logic                ack_tail_o,
  output logic [VEC_W-1:0]    vec_o
);
  import irq_chain_pkg::*;

  logic ack_c [N_STAGES+1];
  logic [VEC_W-1:0] stage_vec [N_STAGES];

  assign ack_c[0] = ack_i;

  for (genvar g = 0; g < N_STAGES; g++) begin : g_stage
    assign stage_vec[g]  = VEC_W'(stage_vector(VEC_BASE, VEC_STRIDE, g));
    assign grant_o[g]    = ack_c[g] & pend_i[g];
    assign ack_c[g+1]    = ack_c[g] & ~pend_i[g];
  end

  assign ack_tail_o = ack_c[N_STAGES];

  always_comb begin
    vec_o = '0;
    for (int i = 0; i < N_STAGES; i++) begin
      if (grant_o[i]) vec_o = vec_o | stage_vec[i];
    end
  end
endmodule

// File: rtl/irq_daisy_chain.sv
module irq_daisy_chain #(
  parameter int          N_STAGES   = 8,
  parameter int          VEC_W      = 8,
  parameter logic [31:0] VEC_BASE   = 32'h20,
  parameter logic [31:0] VEC_STRIDE = 32'h4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [N_STAGES-1:0] src_i,
  input  logic                int_ack_i,
  output logic                int_req_o,
  output logic [VEC_W-1:0]    vec_o,
  output logic                vec_valid_o,
  output logic                spurious_o
);
  // Named internal events, observed by the bound checker.
  logic [N_STAGES-1:0] pend_w;
  logic [N_STAGES-1:0] rise_w;
  logic [N_STAGES-1:0] grant_w;
  logic                ack_tail_w;
  logic                pend_arr [N_STAGES];

  irq_edge_latch #(.N_STAGES(N_STAGES)) u_latch (
    .clk    (clk),
    .rst_n  (rst_n),
    .src_i  (src_i),
    .clr_i  (grant_w),
    .pend_o (pend_w),
    .rise_o (rise_w)
  );

  for (genvar g = 0; g < N_STAGES; g++) begin : g_unpack
    assign pend_arr[g] = pend_w[g];
  end

  irq_ack_chain #(
    .N_STAGES   (N_STAGES),
    .VEC_W      (VEC_W),
    .VEC_BASE   (VEC_BASE),
    .VEC_STRIDE (VEC_STRIDE)
  ) u_chain (
    .pend_i     (pend_arr),
    .ack_i      (int_ack_i),
    .grant_o    (grant_w),
    .ack_tail_o (ack_tail_w),
    .vec_o      (vec_o)
  );

  assign int_req_o   = |pend_w;
  assign vec_valid_o = |grant_w;
  assign spurious_o  = ack_tail_w;
endmodule

// File: rtl/irq_daisy_chain_chk.sv
module irq_daisy_chain_chk #(
  parameter int N_STAGES = 8,
  parameter int VEC_W    = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic                int_ack_i,
  input logic                int_req_o,
  input logic [VEC_W-1:0]    vec_o,
  input logic                vec_valid_o,
  input logic                spurious_o,
  input logic [N_STAGES-1:0] pend_w,
  input logic [N_STAGES-1:0] rise_w
);
  // R1: any caught edge shows up on the shared request next cycle
  a_r1_edge_raises_req: assert property (@(posedge clk) disable iff (!rst_n)
    (|rise_w) |=> int_req_o);

  // R3: a vector is offered only inside an acknowledge cycle
  a_r3_valid_needs_ack: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid_o |-> int_ack_i);

  // R3: an acknowledge meeting a pending request always yields a vector
  a_r3_ack_gets_vector: assert property (@(posedge clk) disable iff (!rst_n)
    (int_ack_i && int_req_o) |-> vec_valid_o);

  // R5: exactly one request leaves per served acknowledge when nothing new arrives
  a_r5_one_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_valid_o && rise_w == '0) |=>
      ($countones(pend_w) == $past($countones(pend_w)) - 1));

  // R6: data lines idle at zero
  a_r6_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !vec_valid_o |-> (vec_o == '0));

  // R7: spurious only when nothing was requesting
  a_r7_spurious_clean: assert property (@(posedge clk) disable iff (!rst_n)
    spurious_o |-> (int_ack_i && !int_req_o && !vec_valid_o));
endmodule

bind irq_daisy_chain irq_daisy_chain_chk #(
  .N_STAGES (N_STAGES),
  .VEC_W    (VEC_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .int_ack_i   (int_ack_i),
  .int_req_o   (int_req_o),
  .vec_o       (vec_o),
  .vec_valid_o (vec_valid_o),
  .spurious_o  (spurious_o),
  .pend_w      (pend_w),
  .rise_w      (rise_w)
);

// File: tb/tb_irq_daisy_chain.sv
`timescale 1ns/1ps
module tb_irq_daisy_chain;
  localparam int N  = 8;
  localparam int VW = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [N-1:0]  src;
  logic          ack;
  logic          req;
  logic [VW-1:0] vec;
  logic          vld;
  logic          spur;

  int checks = 0;
  int fails  = 0;
  int exp_q[$];
  bit done = 0;

  always #2 clk = ~clk;

  irq_daisy_chain #(.N_STAGES(N), .VEC_W(VW)) dut (
    .clk (clk), .rst_n (rst_n), .src_i (src), .int_ack_i (ack),
    .int_req_o (req), .vec_o (vec), .vec_valid_o (vld), .spurious_o (spur)
  );

  // R4 restated: default base 0x20, step 4 per stage.
  function automatic logic [VW-1:0] want_vec(input int idx);
    logic [31:0] w;
    w = 32'd4 * idx + 32'h20;
    return w[VW-1:0];
  endfunction

  task automatic check(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", rq, act, exp);
    end
  endtask

  // Driver: raise then drop the given sources.
  task automatic pulse(input logic [N-1:0] m);
    @(posedge clk); #1 src = m;
    @(posedge clk); #1 src = '0;
  endtask

  // Driver: one acknowledge cycle; exp_idx < 0 means spurious expected.
  task automatic do_ack(input int exp_idx, input logic [N-1:0] src_during);
    @(posedge clk); #1;
    ack = 1'b1;
    src = src_during;
    exp_q.push_back(exp_idx);
    @(posedge clk); #1;
    ack = 1'b0;
  endtask

  // Monitor: compare every acknowledge cycle against the scoreboard.
  always @(negedge clk) begin
    if (rst_n && ack) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R3 unexpected ack", 1, 0);
      end else begin
        int e;
        e = exp_q.pop_front();
        if (e < 0) begin
          check(spur == 1'b1, "R7 spurious flag", spur, 1);
          check(vld == 1'b0,  "R7 no valid", vld, 0);
          check(vec == '0,    "R7 vector zero", vec, 0);
        end else begin
          check(vld == 1'b1,         "R3 valid strobe", vld, 1);
          check(vec == want_vec(e),  "R3/R4 vector", vec, want_vec(e));
          check(spur == 1'b0,        "R7 not spurious", spur, 0);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; src = '0; ack = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R9: reset state
    check(req == 1'b0, "R9 req after reset", req, 0);
    check(vld == 1'b0 && spur == 1'b0, "R9 strobes after reset", {vld, spur}, 0);
    check(vec == '0, "R6 vector idle", vec, 0);

    // R7: acknowledge with nothing pending
    do_ack(-1, '0);

    // R2/R5: single stage
    pulse(8'b0000_1000);
    @(negedge clk);
    check(req == 1'b1, "R2 req raised", req, 1);
    check(vec == '0 && vld == 1'b0, "R6 zero while pending no ack", vec, 0);
    do_ack(3, '0);
    @(negedge clk);
    check(req == 1'b0, "R5 req dropped after grant", req, 0);

    // R3: priority among stages 2, 5, 7
    pulse(8'b1010_0100);
    @(negedge clk);
    check(req == 1'b1, "R2 req with three pending", req, 1);
    do_ack(2, '0);
    @(negedge clk);
    check(req == 1'b1, "R5 others kept", req, 1);
    do_ack(5, '0);
    do_ack(7, '0);
    do_ack(-1, '0);

    // R1: level held high does not re-request
    @(posedge clk); #1 src = 8'b0000_0010;
    do_ack(1, 8'b0000_0010);
    repeat (2) @(posedge clk);
    @(negedge clk);
    check(req == 1'b0, "R1 held level no re-latch", req, 0);
    do_ack(-1, 8'b0000_0010);
    @(posedge clk); #1 src = '0;

    // R8: new edge on the granted stage in the grant cycle
    pulse(8'b0001_0000);
    do_ack(4, 8'b0001_0000);
    @(posedge clk); #1 src = '0;
    @(negedge clk);
    check(req == 1'b1, "R8 request kept after same-cycle edge", req, 1);
    do_ack(4, '0);
    do_ack(-1, '0);

    // R3/R4: all stages at once, served in index order
    pulse('1);
    for (int i = 0; i < N; i++) do_ack(i, '0);
    do_ack(-1, '0);

    // R9: reset mid-flight clears pending
    pulse(8'b0000_0001);
    @(posedge clk); #1 rst_n = 1'b0;
    @(posedge clk); #1 rst_n = 1'b1;
    @(negedge clk);
    check(req == 1'b0, "R9 reset clears pending", req, 0);
    do_ack(-1, '0);

    repeat (2) @(posedge clk);
    check(exp_q.size() == 0, "R3 scoreboard drained", exp_q.size(), 0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule